// File: doc/BRIEF.md
# SPI Flash Slave Command Front End

This block is the serial front end of an SPI NOR flash slave. It runs entirely on a fast system clock and oversamples the serial clock, chip select, hold and data-in lines. Once synchronised, it detects serial clock edges, collects the opcode, address and dummy bytes, and recognises the read and identification commands. It then shifts the response out on the serial data output. A separate output-enable signal stands in for the tri-state pad.

Memory contents come from an external byte-wide read port through a request/acknowledge handshake. The block prefetches each byte during the preceding byte slot, so a continuous read can run for as long as chip select stays low. Each received opcode also produces a one-cycle strobe. The program, erase and status logic elsewhere on the chip uses this strobe to act on commands that this block does not answer itself.

A hold input pauses framing without deselecting the slave. Hold starts and ends only at points where the serial clock is low.

Top module: `spi_flash_front`

## Requirements
- R1: While reset is held, and right after it is released, `so_oe`, `mem_req` and `cmd_stb` are all 0.
- R2: SI is sampled on rising SCK edges and SO changes after falling SCK edges. This holds whether SCK idles low (mode 0) or high (mode 3) when chip select falls.
- R3: Opcode 0x03 takes a 3-byte address, sent most significant byte first, and then streams memory bytes from that address. The address goes up by one after each byte for as long as `cs_n` stays low.
- R4: Opcode 0x0B takes a 3-byte address followed by one dummy byte. The value of the dummy byte has no effect, and the data stream begins at the given address.
- R5: The read address is 18 bits wide. After the byte at 0x3FFFF the stream continues at 0x00000.
- R6: Opcode 0x9F returns 0xBF, 0x25 and 0x8C in that order, and then repeats the same three bytes.
- R7: Opcodes 0x90 and 0xAB take a 3-byte address and then alternate between 0xBF and 0x8C. The stream starts with 0xBF when address bit 0 is 0 and with 0x8C when it is 1.
- R8: When the eighth opcode bit has been received, `cmd_stb` is high for exactly one clock, with `cmd_op` holding that opcode. No strobe is produced for address, dummy or data bytes.
- R9: If `cs_n` rises before a byte is complete, the command is dropped and no strobe is produced. The next command after chip select falls again is decoded normally.
- R10: When HOLD# is low while SCK is low, the slave is held. A HOLD# fall while SCK is high takes effect at the next SCK-low point. While held, `so_oe` is 0 and SCK and SI edges are ignored. Releasing HOLD# while SCK is low resumes the command exactly where it stopped.
- R11: `so_oe` is 0 whenever `cs_n` is high and throughout the opcode, address and dummy phases.
- R12: Once `mem_req` is raised, it stays high with `mem_addr` unchanged until the clock in which `mem_ack` is sampled high. Read data is taken from `mem_rdata` in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Hold request, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so (1 = driven) |
| cmd_stb | output | 1 | One-cycle pulse when an opcode is received |
| cmd_op | output | 8 | Last received opcode |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_ack | input | 1 | Memory read acknowledge |
| mem_rdata | input | 8 | Memory read data, valid with mem_ack |

## Verification
Every serial input passes through a two-flop synchroniser followed by one registered edge detector. As a result, SO, `so_oe` and the state of the hold logic all change three system clocks after the SCK or HOLD# transition that caused them. The bench waits eight system clocks after each falling SCK edge before it samples SO, and waits the same eight clocks after driving HOLD# before it checks `so_oe`, which leaves a margin of five clocks. A prefetch request goes out one clock after the rising edge that completes the last address bit or loads a byte. The modelled memory returns data two clocks later, well within the half SCK period that comes before the next load. The opcode strobe is counted at the system clock edge. The bench compares the strobe count and the last `cmd_op` value only after chip select has risen.

// File: rtl/spi_flash_front.sv
module spi_flash_front #(
  parameter int AW = 18,
  parameter logic [7:0] ID_MFR  = 8'hBF,
  parameter logic [7:0] ID_TYPE = 8'h25,
  parameter logic [7:0] ID_DEV  = 8'h8C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          si,
  input  logic          hold_n,
  output logic          so,
  output logic          so_oe,
  output logic          cmd_stb,
  output logic [7:0]    cmd_op,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata
);
  typedef enum logic [2:0] {S_OPC, S_ADR, S_DUM, S_DAT, S_IGN} st_t;

  logic [2:0]    sck_q;
  logic [1:0]    cs_q, hold_q, si_q;
  logic          held, oe;
  st_t           st;
  logic [2:0]    bcnt;
  logic [1:0]    acnt;
  logic [6:0]    sh;
  logic [7:0]    obuf, rdbuf, id_byte;
  logic [AW-1:0] addr, ptr, nptr;

  wire s_sck = sck_q[1];
  wire s_cs  = cs_q[1];
  wire act   = ~s_cs & ~held;
  wire rise  = act &  s_sck & ~sck_q[2];
  wire fall  = act & ~s_sck &  sck_q[2];
  wire [7:0] nb = {sh, si_q[1]};

  wire op_rd  = (cmd_op == 8'h03) || (cmd_op == 8'h0B);
  wire op_jid = (cmd_op == 8'h9F);

  always_comb begin
    if (op_jid)
      case (ptr[1:0])
        2'd0:    id_byte = ID_MFR;
        2'd1:    id_byte = ID_TYPE;
        default: id_byte = ID_DEV;
      endcase
    else
      id_byte = ptr[0] ? ID_DEV : ID_MFR;
  end

  assign nptr     = (op_jid && ptr[1:0] == 2'd2) ? '0 : ptr + 1'b1;
  assign so       = obuf[7];
  assign so_oe    = oe & ~held;
  assign mem_addr = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= '0; cs_q <= '1; hold_q <= '1; si_q <= '0;
      held <= 1'b0; oe <= 1'b0; st <= S_OPC; bcnt <= '0; acnt <= '0;
      sh <= '0; obuf <= '0; rdbuf <= '0; addr <= '0; ptr <= '0;
      cmd_stb <= 1'b0; cmd_op <= '0; mem_req <= 1'b0;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      cs_q   <= {cs_q[0], cs_n};
      hold_q <= {hold_q[0], hold_n};
      si_q   <= {si_q[0], si};
      cmd_stb <= 1'b0;
      if (mem_ack) begin
        mem_req <= 1'b0;
        rdbuf   <= mem_rdata;
      end
      if (s_cs)        held <= 1'b0;
      else if (!s_sck) held <= ~hold_q[1];

      if (s_cs) begin
        st <= S_OPC; bcnt <= '0; oe <= 1'b0;
      end else begin
        if (rise) begin
          sh   <= nb[6:0];
          bcnt <= bcnt + 1'b1;
          if (bcnt == 3'd7) begin
            case (st)
              S_OPC: begin
                cmd_op <= nb; cmd_stb <= 1'b1; acnt <= '0; ptr <= '0;
                case (nb)
                  8'h03, 8'h0B, 8'h90, 8'hAB: st <= S_ADR;
                  8'h9F:                      st <= S_DAT;
                  default:                    st <= S_IGN;
                endcase
              end
              S_ADR: begin
                addr <= {addr[AW-9:0], nb};
                acnt <= acnt + 1'b1;
                if (acnt == 2'd2) begin
                  ptr <= {addr[AW-9:0], nb};
                  st  <= (cmd_op == 8'h0B) ? S_DUM : S_DAT;
                  if (op_rd) mem_req <= 1'b1;
                end
              end
              S_DUM:   st <= S_DAT;
              default: ;
            endcase
          end
        end
        if (fall && st == S_DAT) begin
          if (bcnt == 3'd0) begin
            obuf <= op_rd ? rdbuf : id_byte;
            oe   <= 1'b1;
            ptr  <= nptr;
            if (op_rd) mem_req <= 1'b1;
          end else begin
            obuf <= {obuf[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_flash_front_chk.sv
module spi_flash_front_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sck,
  input logic          cs_n,
  input logic          hold_n,
  input logic          so_oe,
  input logic          cmd_stb,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack
);
  p_oe_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

  p_stb_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req);

  p_addr_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(mem_addr));

  p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !$past(hold_n) && !$past(hold_n, 2) &&
     !sck && !$past(sck) && !$past(sck, 2)) |=> !so_oe);
endmodule

bind spi_flash_front spi_flash_front_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_spi_flash_front.sv
module sim_spi_flash_front;
  localparam int AW = 18;
  localparam int H  = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, cmd_stb, mem_req, mem_ack;
  logic [7:0] cmd_op, mem_rdata;
  logic [AW-1:0] mem_addr;

  spi_flash_front #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_bad = 0, stb_cnt = 0, hs_bad = 0;
  logic [7:0] last_op = 8'h00;
  bit mode3 = 1'b0, done = 1'b0;
  logic prev_req = 1'b0, prev_ack = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  function automatic logic [7:0] memf(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'd0, a[17:16]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= 8'h00;
    end else begin
      mem_ack   <= mem_req & ~mem_ack;
      mem_rdata <= memf(mem_addr);
      if (cmd_stb) begin stb_cnt <= stb_cnt + 1; last_op <= cmd_op; end
      if (prev_req && !prev_ack && (!mem_req || mem_addr != prev_addr)) hs_bad <= hs_bad + 1;
    end
    prev_req <= mem_req; prev_ack <= mem_ack; prev_addr <= mem_addr;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic r, output logic o);
    sck = 1'b0; si = b; wclk(H);
    r = so; o = so_oe;
    sck = 1'b1; wclk(H);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, inout logic oe_any);
    logic r, o;
    for (int i = 7; i >= 0; i--) begin
      bit_x(tx[i], r, o);
      rx[i] = r;
      oe_any |= o;
    end
  endtask

  task automatic cs_on();
    sck = mode3; wclk(H);
    cs_n = 1'b0; wclk(H);
  endtask

  task automatic cs_off();
    if (!mode3) sck = 1'b0;
    wclk(H);
    cs_n = 1'b1; wclk(2 * H);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wclk(5);
    check("R1 so_oe in reset", so_oe, 0);
    check("R1 mem_req in reset", mem_req, 0);
    rst_n = 1'b1; wclk(2);
    check("R1 cmd_stb after reset", cmd_stb, 0);
  endtask

  task automatic t_read(input string tag, input logic [7:0] opc, input logic [17:0] a,
                        input int n, input bit m3);
    logic [7:0] rx;
    logic oe_cmd = 1'b0, oe_dat;
    int s0 = stb_cnt;
    mode3 = m3;
    cs_on();
    xbyte(opc, rx, oe_cmd);
    xbyte({6'd0, a[17:16]}, rx, oe_cmd);
    xbyte(a[15:8], rx, oe_cmd);
    xbyte(a[7:0], rx, oe_cmd);
    if (opc == 8'h0B) xbyte(8'h5A, rx, oe_cmd);
    check({tag, " R11 no drive in command phase"}, oe_cmd, 0);
    for (int k = 0; k < n; k++) begin
      logic [17:0] aa = a + k[17:0];
      oe_dat = 1'b0;
      xbyte(8'h00, rx, oe_dat);
      check({tag, " data"}, rx, memf(aa));
      check({tag, " R2 output driven"}, oe_dat, 1);
    end
    cs_off();
    check({tag, " R11 released after CS"}, so_oe, 0);
    check({tag, " R8 one strobe"}, stb_cnt - s0, 1);
    check({tag, " R8 opcode"}, last_op, opc);
  endtask

  function automatic logic [7:0] idexp(input logic [7:0] opc, input bit a0, input int k);
    if (opc == 8'h9F) return (k % 3 == 0) ? 8'hBF : (k % 3 == 1) ? 8'h25 : 8'h8C;
    return ((k + a0) % 2 == 0) ? 8'hBF : 8'h8C;
  endfunction

  task automatic t_id(input string tag, input logic [7:0] opc, input bit a0, input int n);
    logic [7:0] rx;
    logic oe_any = 1'b0;
    mode3 = 1'b0;
    cs_on();
    xbyte(opc, rx, oe_any);
    if (opc != 8'h9F) begin
      xbyte(8'h00, rx, oe_any); xbyte(8'h00, rx, oe_any); xbyte({7'd0, a0}, rx, oe_any);
    end
    for (int k = 0; k < n; k++) begin
      xbyte(8'hFF, rx, oe_any);
      check(tag, rx, idexp(opc, a0, k));
    end
    cs_off();
  endtask

  task automatic t_abort();
    logic r, o;
    int s0 = stb_cnt;
    mode3 = 1'b0;
    cs_on();
    for (int i = 7; i >= 4; i--) bit_x(u8(8'h9F, i), r, o);
    cs_off();
    check("R9 no strobe on aborted byte", stb_cnt - s0, 0);
    t_id("R9 command after abort", 8'h9F, 1'b0, 3);
  endtask

  function automatic logic u8(input logic [7:0] v, input int i);
    return v[i];
  endfunction

  task automatic toggle3();
    repeat (3) begin
      sck = 1'b1; si = ~si; wclk(H);
      sck = 1'b0; wclk(H);
    end
  endtask

  task automatic t_hold();
    logic [7:0] rx;
    logic oe_any = 1'b0;
    logic [17:0] a = 18'h00200;
    mode3 = 1'b0;
    cs_on();
    xbyte(8'h03, rx, oe_any);
    xbyte(8'h00, rx, oe_any);
    sck = 1'b0; wclk(H);
    hold_n = 1'b0; wclk(H);
    toggle3();
    hold_n = 1'b1; wclk(H);
    xbyte(a[15:8], rx, oe_any);
    xbyte(a[7:0], rx, oe_any);
    xbyte(8'h00, rx, oe_any);
    check("R10 address unaffected by held clocks", rx, memf(a));
    hold_n = 1'b0; wclk(H);
    check("R10 hold deferred while SCK high", so_oe, 1);
    sck = 1'b0; wclk(H);
    check("R10 output released while held", so_oe, 0);
    toggle3();
    check("R10 still held", so_oe, 0);
    hold_n = 1'b1; wclk(H);
    check("R10 output back after release", so_oe, 1);
    xbyte(8'h00, rx, oe_any);
    check("R10 stream resumes", rx, memf(a + 18'd1));
    cs_off();
  endtask

  initial begin
    wclk(150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_read("R3 read mode0", 8'h03, 18'h01234, 4, 1'b0);
    t_read("R2 read mode3", 8'h03, 18'h2ABCD, 3, 1'b1);
    t_read("R4 fast read", 8'h0B, 18'h00100, 3, 1'b0);
    t_read("R4 fast read mode3", 8'h0B, 18'h1F0F0, 2, 1'b1);
    t_read("R5 wrap", 8'h03, 18'h3FFFE, 4, 1'b0);
    t_id("R6 jedec id", 8'h9F, 1'b0, 4);
    t_id("R7 id 90 a0=0", 8'h90, 1'b0, 3);
    t_id("R7 id AB a0=1", 8'hAB, 1'b1, 3);
    t_abort();
    t_hold();
    wclk(10);
    check("R12 handshake violations", hs_bad, 0);
    check("R11 idle output enable", so_oe, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule